// File: doc/BRIEF.md
# Programmable Tap-Select Interval Timer

This block is a synchronous interval timer for slow periodic or one-time events. A 16-bit binary counter advances by one on each rising edge of a count strobe, `tick_i`. The strobe is sampled on the system clock. A two-bit select input picks one of four counter stages, N. The chosen stage drives the output, and a polarity input can invert it.

The block has two output behaviours:

- **Recycle mode.** The output is a free-running square wave with a period of 2^N strobe edges.
- **Single-transition mode.** After a reset, the output makes exactly one transition, after 2^(N-1) strobe edges. It then stays there.

There are two reset paths. A power-on pulse always clears the timer. If the power-up start input is enabled, counting begins at once. If it is disabled, counting waits until a master reset has been asserted and released. The master reset clears the counter and the one-shot latch, and it holds counting off while it is asserted.

Top module: `tap_interval_timer`

## Requirements
- R1: After a power-on pulse with the power-up start enabled (`autostart_n_i` = 0), the counter is zero and `out_o` equals `inv_i` (low with true polarity).
- R2: The counter advances by exactly one for each 0-to-1 transition of `tick_i`. Holding `tick_i` high for several clocks counts once.
- R3: The stage tapped is chosen by `sel_i` = {A,B}, where `sel_i[1]` is A and `sel_i[0]` is B. The mapping is: 2'b00 selects N=13, 2'b01 selects N=10, 2'b10 selects N=8, and 2'b11 selects N=16.
- R4: With `mode_i` = 1, the true output equals counter bit N-1. It toggles every 2^(N-1) counts, giving a period of 2^N counts, and it wraps at 2^16.
- R5: With `mode_i` = 0, after a reset the true output is low. It goes high on the count that brings the total to 2^(N-1).
- R6: In `mode_i` = 0, once the output has gone high, the latch holds it there and the counter stops advancing. This lasts until a master reset, or until `mode_i` becomes 1. From that point the output follows bit N-1 of the frozen count.
- R7: With `inv_i` = 1, the output is the complement of the true output in both modes, so it starts high after reset.
- R8: After a power-on pulse with `autostart_n_i` = 1, strobes have no effect until `mreset_i` has been asserted and then released.
- R9: While `mreset_i` is 1, the counter and latch are cleared and strobes are ignored. Counting resumes from zero after release.
- R10: A change of `sel_i` or `mode_i` reaches `out_o` at the next clock edge, and it does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high, synchronous |
| autostart_n_i | input | 1 | 0: count right after power-on; 1: wait for a master reset |
| mreset_i | input | 1 | Master reset, active high |
| tick_i | input | 1 | Count strobe; rising transitions are counted |
| sel_i | input | 2 | Stage select {A,B} |
| mode_i | input | 1 | 1: recycle square wave; 0: single transition |
| inv_i | input | 1 | 1: invert the output |
| out_o | output | 1 | Registered timer output |

## Verification
Internal state is visible only through the one output bit, so a wrong count shows up late. A counter that skips or double-counts moves the tapped edge by whole counts. That error appears only at the next transition of the selected stage: up to 2^(N-1) strobes later. For this reason the bench follows every strobe against an independent model, at every stage and in both modes.

A latch that fails to freeze the counter stays invisible in single-transition mode. It is exposed by switching to recycle mode and measuring when the output next falls. A start gate that opens early shows as a transition while the timer should still be waiting.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

    localparam int CNT_W_DEF = 16;

    localparam int STG_00_DEF = 13;
    localparam int STG_01_DEF = 10;
    localparam int STG_10_DEF = 8;
    localparam int STG_11_DEF = 16;

    typedef logic [1:0] stage_sel_t;

endpackage

// File: rtl/tpt_strobe_edge.sv
module tpt_strobe_edge (
    input  logic clk,
    input  logic por_i,
    input  logic tick_i,
    output logic rise_o
);

    logic tick_d, tick_q;

    always_comb begin
        tick_d = tick_i;
        rise_o = tick_i & ~tick_q;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_d;
        end
    end

    // a held strobe never yields two rises in a row
    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (por_i)
        rise_o |=> !rise_o) else $error("double rise"); // R2

endmodule

// File: rtl/tpt_start_gate.sv
module tpt_start_gate (
    input  logic clk,
    input  logic por_i,
    input  logic autostart_n_i,
    input  logic mreset_i,
    output logic waiting_o,
    output logic run_o
);

    typedef struct packed {
        logic waiting;
        logic mr_prev;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.mr_prev = mreset_i;
        // first release of master reset opens the gate
        if (st_q.mr_prev && !mreset_i) begin
            st_d.waiting = 1'b0;
        end
        waiting_o = st_q.waiting;
        run_o     = !st_q.waiting && !mreset_i;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            st_q.waiting <= autostart_n_i;
            st_q.mr_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // the gate only opens through a master reset release
    AST_GATE_OPENS_ON_RELEASE: assert property (@(posedge clk) disable iff (por_i)
        (waiting_o && !(st_q.mr_prev && !mreset_i)) |=> waiting_o)
        else $error("gate opened without release"); // R8

endmodule

// File: rtl/tpt_stage_mux.sv
module tpt_stage_mux
    import tpt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int STG_00 = STG_00_DEF,
    parameter int STG_01 = STG_01_DEF,
    parameter int STG_10 = STG_10_DEF,
    parameter int STG_11 = STG_11_DEF
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  stage_sel_t       sel_i,
    output logic             tap_o
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] bit_idx;

    // non-monotonic encoding: the stage depth does not follow sel order
    always_comb begin
        unique case (sel_i)
            2'b00:   bit_idx = IDX_W'(STG_00 - 1);
            2'b01:   bit_idx = IDX_W'(STG_01 - 1);
            2'b10:   bit_idx = IDX_W'(STG_10 - 1);
            default: bit_idx = IDX_W'(STG_11 - 1);
        endcase
        tap_o = cnt_i[bit_idx];
    end

endmodule

// File: rtl/tap_interval_timer.sv
module tap_interval_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int STG_00 = STG_00_DEF,
    parameter int STG_01 = STG_01_DEF,
    parameter int STG_10 = STG_10_DEF,
    parameter int STG_11 = STG_11_DEF
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       autostart_n_i,
    input  logic       mreset_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    input  logic       mode_i,
    input  logic       inv_i,
    output logic       out_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             latch;
        logic             out;
    } core_st_t;

    core_st_t st_d, st_q;

    logic rise;
    logic run;
    logic waiting;
    logic tap_next;
    logic count_en;

    tpt_strobe_edge u_edge (
        .clk    (clk),
        .por_i  (por_i),
        .tick_i (tick_i),
        .rise_o (rise)
    );

    tpt_start_gate u_gate (
        .clk           (clk),
        .por_i         (por_i),
        .autostart_n_i (autostart_n_i),
        .mreset_i      (mreset_i),
        .waiting_o     (waiting),
        .run_o         (run)
    );

    // tap is taken from the next count so the output lines up with it
    tpt_stage_mux #(
        .CNT_W  (CNT_W),
        .STG_00 (STG_00),
        .STG_01 (STG_01),
        .STG_10 (STG_10),
        .STG_11 (STG_11)
    ) u_mux (
        .cnt_i (st_d.cnt),
        .sel_i (stage_sel_t'(sel_i)),
        .tap_o (tap_next)
    );

    always_comb begin
        st_d     = st_q;
        // a set latch in single-transition mode freezes the count
        count_en = rise && run && !(!mode_i && st_q.latch);

        if (mreset_i) begin
            st_d.cnt = '0;
        end else if (count_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    core_st_t st_fin;

    always_comb begin
        st_fin = st_d;
        if (mreset_i || mode_i) begin
            st_fin.latch = 1'b0;
        end else begin
            st_fin.latch = st_q.latch | tap_next;
        end
        st_fin.out = (mode_i ? tap_next : st_fin.latch) ^ inv_i;
        out_o      = st_q.out;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            st_q.cnt   <= '0;
            st_q.latch <= 1'b0;
            st_q.out   <= inv_i;
        end else begin
            st_q <= st_fin;
        end
    end

    AST_MR_CLEARS: assert property (@(posedge clk) disable iff (por_i)
        mreset_i |=> (st_q.cnt == '0 && !st_q.latch))
        else $error("master reset did not clear"); // R9

    AST_FROZEN_LATCH: assert property (@(posedge clk) disable iff (por_i)
        (!mode_i && st_q.latch && !mreset_i) |=> $stable(st_q.cnt))
        else $error("counter moved after latch"); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (por_i)
        (!mode_i && st_q.latch && !mreset_i) |=> st_q.latch)
        else $error("latch dropped"); // R6

    AST_NO_LATCH_RECYCLE: assert property (@(posedge clk) disable iff (por_i)
        mode_i |=> !st_q.latch)
        else $error("latch set in recycle mode"); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (por_i)
        (st_q.cnt != $past(st_q.cnt)) |->
            (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1) || st_q.cnt == '0))
        else $error("counter jumped"); // R2

    AST_WAIT_NO_COUNT: assert property (@(posedge clk) disable iff (por_i)
        (waiting && !mreset_i) |=> $stable(st_q.cnt))
        else $error("counted while waiting"); // R8

endmodule

// File: tb/sim_tap_interval_timer.sv
`timescale 1ns/1ps
module sim_tap_interval_timer;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       autostart_n_i = 1'b0;
    logic       mreset_i = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] sel_i = 2'b10;
    logic       mode_i = 1'b1;
    logic       inv_i = 1'b0;
    logic       out_o;

    always #5 clk = ~clk;

    tap_interval_timer u0 (
        .clk           (clk),
        .por_i         (por_i),
        .autostart_n_i (autostart_n_i),
        .mreset_i      (mreset_i),
        .tick_i        (tick_i),
        .sel_i         (sel_i),
        .mode_i        (mode_i),
        .inv_i         (inv_i),
        .out_o         (out_o)
    );

    typedef struct {
        logic  val;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt   = 0;
    bit m_latch = 1'b0;
    bit m_wait  = 1'b0;
    bit m_mr    = 1'b0;

    function automatic int stage_of(logic [1:0] s);
        case (s)
            2'b00:   return 13;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic bit tap_bit();
        return ((m_cnt >> (stage_of(sel_i) - 1)) & 1) != 0;
    endfunction

    function automatic logic model_out();
        bit t;
        if (mode_i) t = tap_bit();
        else        t = m_latch;
        return t ^ inv_i;
    endfunction

    function automatic void model_settle();
        if (m_mr) begin
            m_cnt = 0;
            m_latch = 1'b0;
        end
        if (mode_i) m_latch = 1'b0;
        else if (tap_bit()) m_latch = 1'b1;
    endfunction

    task automatic push(string req);
        exp_item_t it;
        it.val = model_out();
        it.req = req;
        exp_q.push_back(it);
    endtask

    // one strobe, then the expected output is queued
    task automatic pulse(string req);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        if (!m_mr && !m_wait && !(!mode_i && m_latch))
            m_cnt = (m_cnt + 1) % 65536;
        model_settle();
        push(req);
    endtask

    task automatic pulses(int n, string req);
        for (int i = 0; i < n; i++) pulse(req);
    endtask

    task automatic long_pulse(string req);
        @(negedge clk) tick_i = 1'b1;
        repeat (4) @(negedge clk);
        tick_i = 1'b0;
        if (!m_mr && !m_wait && !(!mode_i && m_latch))
            m_cnt = (m_cnt + 1) % 65536;
        model_settle();
        push(req);
    endtask

    // settle one clock after a control change, then queue
    task automatic settle_check(string req);
        @(negedge clk);
        model_settle();
        push(req);
    endtask

    task automatic do_por(bit autodis);
        @(negedge clk);
        por_i = 1'b1;
        autostart_n_i = autodis;
        repeat (2) @(negedge clk);
        por_i = 1'b0;
        m_cnt = 0;
        m_latch = 1'b0;
        m_wait = autodis;
    endtask

    task automatic do_mreset(string req);
        @(negedge clk) mreset_i = 1'b1;
        m_mr = 1'b1;
        model_settle();
        pulses(3, req);
        @(negedge clk) mreset_i = 1'b0;
        m_mr = 1'b0;
        m_wait = 1'b0;
        repeat (2) @(negedge clk);
        push(req);
    endtask

    // monitor: compare every queued expectation after the driver's edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (out_o !== it.val) begin
                    errors++;
                    $display("FAIL %s: out_o=%b expected=%b (count model %0d, sel %b, mode %b)",
                             it.req, out_o, it.val, m_cnt, sel_i, mode_i);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: power-on with start enabled, true polarity
        sel_i = 2'b10; mode_i = 1'b1; inv_i = 1'b0;
        do_por(1'b0);
        settle_check("R1 reset output low");

        // R4 and R2: recycle mode at N=8, including a held strobe
        pulses(126, "R4 recycle N=8 low half");
        long_pulse("R2 held strobe counts once");
        pulses(400, "R4 recycle N=8 period");

        // R9: strobes ignored while master reset held
        do_mreset("R9 master reset clears");

        // R5: single transition at N=8, then R6: counter frozen
        mode_i = 1'b0;
        settle_check("R10 mode change");
        pulses(140, "R5 one-shot N=8 rises at 128");
        mode_i = 1'b1;
        settle_check("R6 mode to recycle shows frozen count");
        pulses(128, "R6 frozen count then falls after 128");

        // R7: inverted single transition
        inv_i = 1'b1;
        mode_i = 1'b0;
        settle_check("R7 polarity change");
        do_mreset("R7 inverted start high");
        pulses(130, "R7 inverted one-shot falls at 128");
        inv_i = 1'b0;
        settle_check("R7 back to true polarity");

        // R3: N=10 in both modes
        sel_i = 2'b01;
        do_mreset("R3 select N=10 reset");
        pulses(520, "R3 one-shot N=10 at 512");
        mode_i = 1'b1;
        do_mreset("R3 recycle N=10 reset");
        pulses(2100, "R3 recycle N=10 period 1024");

        // R3: N=13
        sel_i = 2'b00;
        mode_i = 1'b0;
        do_mreset("R3 select N=13 reset");
        pulses(4100, "R3 one-shot N=13 at 4096");
        mode_i = 1'b1;
        settle_check("R6 N=13 release to recycle");
        pulses(4096, "R4 recycle N=13 falls at 8192");

        // R3: N=16
        sel_i = 2'b11;
        mode_i = 1'b0;
        do_mreset("R3 select N=16 reset");
        pulses(32770, "R3 one-shot N=16 at 32768");
        mode_i = 1'b1;
        settle_check("R6 N=16 release to recycle");
        pulses(32768, "R4 recycle N=16 wraps at 65536");

        // R10: select change without counter reset
        sel_i = 2'b10;
        do_mreset("R10 reset before select test");
        pulses(200, "R10 count to 200 at N=8");
        sel_i = 2'b01;
        settle_check("R10 switch to N=10");
        pulses(100, "R10 count on at N=10");
        sel_i = 2'b10;
        settle_check("R10 switch back to N=8");
        pulses(100, "R10 count kept across switches");

        // R8: power-up start disabled, waits for master reset release
        sel_i = 2'b10;
        mode_i = 1'b0;
        do_por(1'b1);
        settle_check("R8 reset output low");
        pulses(200, "R8 no counting before master reset");
        do_mreset("R8 master reset opens gate");
        pulses(130, "R8 counting after release");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule